// File: doc/BRIEF.md
# Serial SRAM SPI Host Controller

This block sits on the host side of a byte-organised serial SRAM and converts single requests into complete SPI frames. A request carries an operation, a 15-bit word address and a byte count. The controller drives chip select, the serial clock and the serial output line, and samples the memory's serial data line. The four operations are status-register write, status-register read, memory read and memory write. Memory transfers longer than one byte rely on the memory's sequential (page or burst) mode. Software must set that mode through a status write beforehand; the controller keeps clocking as long as the request asks.

Write bytes come from a byte stream that the controller pulls with a one-cycle strobe. Each byte is taken at the moment its first bit is due on the wire. Read bytes leave on a byte stream with a one-cycle valid strobe, as soon as their eighth bit has been sampled. All SPI timing is derived from the system clock. `HALF_DIV` system clocks form one half-period of the serial clock. The select setup, the select hold after the last rising edge and the deselected gap between frames are each a whole number of half-periods.

Top module: `sram_spi_host`

## Requirements
- R1: After reset, and whenever no frame is in progress, `spi_cs_n` is 1, `spi_sck` is 0 and `req_ready` is 1, while `done`, `rd_valid` and `wr_ready` are 0.
- R2: Every frame starts with an 8-bit command sent MSB first. The command is 0x01 for status write (`req_op`=0), 0x05 for status read (`req_op`=1), 0x03 for memory read (`req_op`=2) and 0x02 for memory write (`req_op`=3).
- R3: For memory operations, the command is followed by a 16-bit address field, MSB first, whose top bit is 0 and whose low 15 bits are `req_addr`.
- R4: A memory request of N bytes gives exactly 24+8N rising serial-clock edges while selected. `req_len`=0 counts as N=1. Status operations give exactly 16.
- R5: The serial clock idles low. `spi_mosi` changes only while the serial clock is low. Each clock phase lasts at least `HALF_DIV` system clocks, which is at least 25 ns at the default settings.
- R6: Chip select falls at least `LEAD_HALVES` half-periods before the first rising edge. It rises at least 1+`TRAIL_HALVES` half-periods after the last rising edge, and stays high at least `GAP_HALVES` half-periods before the next frame. With the defaults these are at least 25 ns, 50 ns and 25 ns.
- R7: For memory and status writes, each data byte is taken from `wr_data` in the cycle where `wr_ready` pulses, in stream order, and sent MSB first.
- R8: For memory and status reads, `spi_miso` is sampled on each rising edge. Each data byte appears on `rd_data`, MSB first assembled, with a one-cycle `rd_valid` pulse in the cycle of its eighth sampling edge.
- R9: `done` pulses for one cycle, together with chip select rising. `req_ready` stays low from acceptance until the deselected gap has elapsed.
- R10: `req_op`, `req_addr` and `req_len` are captured at acceptance, and changes to them during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_op | input | 2 | 0 status write, 1 status read, 2 memory read, 3 memory write |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Byte count for memory operations (0 means 1) |
| wr_data | input | 8 | Next byte of the write stream |
| wr_ready | output | 1 | Pulse: `wr_data` consumed |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Pulse: `rd_data` valid |
| done | output | 1 | Pulse: frame closed |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
The bound checker watches the cycle-level invariants on every cycle. These are: the clock stays low while deselected, the output line holds steady while the clock is high, and no clock phase is shorter than the divider. It also checks that `done` coincides with chip select rising, that `req_ready` never shows during a frame, and where the two stream strobes may fire. The frame content can only be shown by the bench's scenarios, which use a behavioural memory on the serial pins. That content covers the command bytes, the address field, the exact edge count for each length, in-order delivery across the top address wrap, and that request fields are ignored after acceptance. The scenarios also measure the setup, hold and gap times in nanoseconds.

// File: rtl/sram_spi_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial SRAM host controller.
// Assumes: operation encoding is fixed by the request port definition.
package sram_spi_pkg;

    typedef enum logic [1:0] {
        OP_STAT_WR = 2'd0,
        OP_STAT_RD = 2'd1,
        OP_MEM_RD  = 2'd2,
        OP_MEM_WR  = 2'd3
    } req_op_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LEAD  = 3'd1,
        PH_SHIFT = 3'd2,
        PH_TRAIL = 3'd3,
        PH_GAP   = 3'd4
    } phase_e;

    // Command byte sent on the wire for each request type
    function automatic logic [7:0] cmd_byte(req_op_e op);
        case (op)
            OP_STAT_WR: cmd_byte = 8'h01;
            OP_STAT_RD: cmd_byte = 8'h05;
            OP_MEM_RD:  cmd_byte = 8'h03;
            default:    cmd_byte = 8'h02;
        endcase
    endfunction

    function automatic logic is_status(req_op_e op);
        is_status = (op == OP_STAT_WR) || (op == OP_STAT_RD);
    endfunction

    function automatic logic is_reader(req_op_e op);
        is_reader = (op == OP_STAT_RD) || (op == OP_MEM_RD);
    endfunction

endpackage

// File: rtl/sram_spi_halftimer.sv
`timescale 1ns/1ps
// Half-period strobe generator for the serial clock.
// Counts system clocks while run is high and pulses tick once every
// HALF_DIV clocks; the count restarts from zero whenever run drops.
// Assumes: HALF_DIV >= 2.
module sram_spi_halftimer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    // Free-running count within a half-period, cleared when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sram_spi_bytesel.sv
`timescale 1ns/1ps
// Selects the byte to place on the wire at a given byte index of a frame.
// Index 0 is the command; memory frames then carry two address bytes
// (top bit forced to zero); all later indices are data bytes.
// Assumes: ADDR_W <= 15 so the address fits a 16-bit field with a zero MSB.
module sram_spi_bytesel
    import sram_spi_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int IDX_W  = 10
) (
    input  req_op_e           op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_byte,
    output logic [7:0]        byte_o,
    output logic              take_o
);
    logic [15:0] addr_field;
    logic        data_slot;

    assign addr_field = 16'(addr);

    // Classify the index as header or payload
    always_comb begin
        if (is_status(op)) data_slot = (idx != '0);
        else               data_slot = (idx > IDX_W'(2));
    end

    // Pick the outgoing byte and flag a write-stream pull
    always_comb begin
        take_o = 1'b0;
        byte_o = 8'h00;
        if (idx == '0) begin
            byte_o = cmd_byte(op);
        end else if (!data_slot) begin
            byte_o = (idx == IDX_W'(1)) ? addr_field[15:8] : addr_field[7:0];
        end else if (!is_reader(op)) begin
            byte_o = wr_byte;
            take_o = 1'b1;
        end
    end
endmodule

// File: rtl/sram_spi_host.sv
`timescale 1ns/1ps
// Host-side SPI controller for a byte-wide serial SRAM.
// Accepts one request at a time, builds the frame (command, optional
// address, data), honours select setup/hold/gap in half-periods of the
// serial clock and streams bytes in and out.
// Assumes: HALF_DIV >= 2, every *_HALVES >= 1, the write stream always
// holds the next byte when wr_ready pulses.
module sram_spi_host
    import sram_spi_pkg::*;
#(
    parameter int HALF_DIV     = 4,
    parameter int LEAD_HALVES  = 1,
    parameter int TRAIL_HALVES = 1,
    parameter int GAP_HALVES   = 1,
    parameter int ADDR_W       = 15,
    parameter int LEN_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        wr_data,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int IDX_W  = LEN_W + 2;
    localparam int MAX_HV = (LEAD_HALVES > TRAIL_HALVES)
                          ? ((LEAD_HALVES > GAP_HALVES) ? LEAD_HALVES : GAP_HALVES)
                          : ((TRAIL_HALVES > GAP_HALVES) ? TRAIL_HALVES : GAP_HALVES);
    localparam int PH_W   = $clog2(MAX_HV + 1);

    phase_e            phase_q;
    req_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  total_q, idx_q, req_total, hdr_len;
    logic [2:0]        bit_q;
    logic [7:0]        tx_q, rx_q, next_byte;
    logic [PH_W-1:0]   hv_q;
    logic              tick, take_next, accept, rise_now, fall_now, last_bit;
    req_op_e           req_op_t;

    assign req_op_t  = req_op_e'(req_op);
    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_ready && req_valid;
    assign spi_mosi  = tx_q[7];
    assign hdr_len   = is_status(op_q) ? IDX_W'(1) : IDX_W'(3);
    assign last_bit  = (bit_q == 3'd7) && (idx_q == total_q - 1'b1);
    assign rise_now  = tick && ((phase_q == PH_LEAD && hv_q == PH_W'(LEAD_HALVES - 1))
                             || (phase_q == PH_SHIFT && !spi_sck));
    assign fall_now  = tick && (phase_q == PH_SHIFT) && spi_sck;

    // Number of bytes in the frame for the offered request
    always_comb begin
        if (is_status(req_op_t))  req_total = IDX_W'(2);
        else if (req_len == '0)   req_total = IDX_W'(4);
        else                      req_total = IDX_W'(3) + IDX_W'(req_len);
    end

    sram_spi_halftimer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (phase_q != PH_IDLE),
        .tick (tick)
    );

    sram_spi_bytesel #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_sel (
        .op     (op_q),
        .idx    (idx_q + 1'b1),
        .addr   (addr_q),
        .wr_byte(wr_data),
        .byte_o (next_byte),
        .take_o (take_next)
    );

    // Frame sequencer: select timing, clock toggling, shifting and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            op_q     <= OP_STAT_WR;
            addr_q   <= '0;
            total_q  <= '0;
            idx_q    <= '0;
            bit_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            hv_q     <= '0;
            spi_cs_n <= 1'b1;
            spi_sck  <= 1'b0;
            done     <= 1'b0;
            wr_ready <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            done     <= 1'b0;
            wr_ready <= 1'b0;
            rd_valid <= 1'b0;
            if (accept) begin
                op_q     <= req_op_t;
                addr_q   <= req_addr;
                total_q  <= req_total;
                idx_q    <= '0;
                bit_q    <= '0;
                tx_q     <= cmd_byte(req_op_t);
                hv_q     <= '0;
                spi_cs_n <= 1'b0;
                phase_q  <= PH_LEAD;
            end
            if (rise_now) begin
                spi_sck <= 1'b1;
                phase_q <= PH_SHIFT;
                rx_q    <= {rx_q[6:0], spi_miso};
                if (bit_q == 3'd7 && idx_q >= hdr_len && is_reader(op_q)) begin
                    rd_valid <= 1'b1;
                    rd_data  <= {rx_q[6:0], spi_miso};
                end
            end else if (tick && phase_q == PH_LEAD) begin
                hv_q <= hv_q + 1'b1;
            end
            if (fall_now) begin
                spi_sck <= 1'b0;
                if (last_bit) begin
                    phase_q <= PH_TRAIL;
                    hv_q    <= '0;
                end else if (bit_q == 3'd7) begin
                    tx_q     <= next_byte;
                    idx_q    <= idx_q + 1'b1;
                    bit_q    <= '0;
                    wr_ready <= take_next;
                end else begin
                    tx_q  <= {tx_q[6:0], 1'b0};
                    bit_q <= bit_q + 1'b1;
                end
            end
            if (tick && phase_q == PH_TRAIL) begin
                if (hv_q == PH_W'(TRAIL_HALVES - 1)) begin
                    spi_cs_n <= 1'b1;
                    done     <= 1'b1;
                    phase_q  <= PH_GAP;
                    hv_q     <= '0;
                end else begin
                    hv_q <= hv_q + 1'b1;
                end
            end
            if (tick && phase_q == PH_GAP) begin
                if (hv_q == PH_W'(GAP_HALVES - 1)) phase_q <= PH_IDLE;
                else                               hv_q    <= hv_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sram_spi_host_chk.sv
`timescale 1ns/1ps
// Property checker for sram_spi_host, attached by bind.
// Tracks how long the serial clock holds each level to check the
// minimum phase width without deep history.
module sram_spi_host_chk #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic wr_ready,
    input logic rd_valid,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);
    localparam int RUN_W = $clog2(HALF_DIV + 1) + 1;

    logic             sck_q;
    logic [RUN_W-1:0] run_q;

    // Length of the current serial-clock level, saturating at HALF_DIV
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            run_q <= '0;
        end else begin
            sck_q <= spi_sck;
            if (spi_sck != sck_q)                run_q <= RUN_W'(1);
            else if (run_q < RUN_W'(HALF_DIV))   run_q <= run_q + 1'b1;
        end
    end

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R5
    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi)); // R5
    AST_PHASE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck != sck_q) |-> (run_q >= RUN_W'(HALF_DIV))); // R5
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n); // R9
    AST_DONE_WITH_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(spi_cs_n)); // R9
    AST_CS_RISE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> done); // R9
    AST_GAP_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> !req_ready); // R6
    AST_RD_STROBE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!spi_cs_n && spi_sck)); // R8
    AST_RD_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R8
    AST_WR_PULL_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!spi_cs_n && !spi_sck)); // R7
endmodule

bind sram_spi_host sram_spi_host_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .done     (done),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
);

// File: tb/sim_sram_spi_host.sv
`timescale 1ns/1ps
// Scoreboard bench: request tasks queue expected read bytes and write
// bytes; monitors pop them as the controller strobes; a behavioural
// serial memory on the pins records frame content and timing.
module sim_sram_spi_host;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_ready, rd_valid, done;
    logic [7:0]  rd_data;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sram_spi_host u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_ready(wr_ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .done(done), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- behavioural serial memory ----------------
    logic [7:0]  mem [0:32767];
    logic [7:0]  stat_reg = 8'h00;
    logic [7:0]  cmd, in_sh, out_byte, last_cmd;
    logic [15:0] adr_sh, last_adr;
    logic [14:0] ptr;
    int          rises = 0, last_rises = 0;
    realtime     t_fall = 0, t_rise = 0, t_last = 0, t_edge = 0;
    real         min_setup = 1.0e9, min_hold = 1.0e9, min_gap = 1.0e9, min_half = 1.0e9;
    bit          seen_frame = 1'b0, edge_seen = 1'b0;

    always @(negedge spi_cs_n) begin
        if (seen_frame && ($realtime - t_rise) < min_gap) min_gap = $realtime - t_rise;
        t_fall = $realtime; rises = 0; edge_seen = 1'b0; cmd = 8'h00;
    end

    always @(posedge spi_cs_n) begin
        if (rises > 0) begin
            t_rise = $realtime; seen_frame = 1'b1; last_rises = rises; last_cmd = cmd;
            if (($realtime - t_last) < min_hold) min_hold = $realtime - t_last;
        end
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (rises == 0 && ($realtime - t_fall) < min_setup) min_setup = $realtime - t_fall;
            if (edge_seen && ($realtime - t_edge) < min_half) min_half = $realtime - t_edge;
            t_edge = $realtime; edge_seen = 1'b1; t_last = $realtime;
            in_sh = {in_sh[6:0], spi_mosi};
            rises++;
            if (rises == 8) cmd = in_sh;
            if (rises > 8 && rises <= 24) adr_sh = {adr_sh[14:0], spi_mosi};
            if (rises == 24 && (cmd == 8'h02 || cmd == 8'h03)) begin
                ptr = adr_sh[14:0]; last_adr = adr_sh;
            end
            if (cmd == 8'h02 && rises > 24 && (rises - 24) % 8 == 0) begin
                mem[ptr] = in_sh; ptr = ptr + 15'd1;
            end
            if (cmd == 8'h01 && rises == 16) stat_reg = in_sh;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (edge_seen && ($realtime - t_edge) < min_half) min_half = $realtime - t_edge;
            t_edge = $realtime;
            if (cmd == 8'h03 && rises >= 24) begin
                if ((rises - 24) % 8 == 0) begin out_byte = mem[ptr]; ptr = ptr + 15'd1; end
                spi_miso = out_byte[7 - ((rises - 24) % 8)];
            end
            if (cmd == 8'h05 && rises >= 8) begin
                if ((rises - 8) % 8 == 0) out_byte = stat_reg;
                spi_miso = out_byte[7 - ((rises - 8) % 8)];
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [7:0] exp_q[$];
    logic [7:0] wr_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: read bytes against expectations, write-stream pulls
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R8", "unexpected read byte", rd_data, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R8", "read byte", rd_data, e);
            end
        end
        if (rst_n && wr_ready) begin
            if (wr_q.size() == 0) check(1'b0, "R7", "write pull with empty stream", 1, 0);
            else void'(wr_q.pop_front());
            wr_data = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
        end
    end

    // Driver: offer a request, scramble fields after acceptance, wait for done
    task automatic run_req(input logic [1:0] op, input logic [14:0] a, input logic [7:0] n);
        wr_data = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_len = n;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a; req_len = 8'd9;     // R10: must not disturb the frame
        @(negedge clk);
        while (!done) @(negedge clk);
        check(spi_cs_n == 1'b1, "R9", "cs high with done", spi_cs_n, 1);
        check(req_ready == 1'b0, "R9", "ready low during gap", req_ready, 0);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            check(1'b0, "R1", "watchdog expired", cyc, 100000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32768; i++) mem[i] = 8'(i) ^ 8'h3C;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        check(spi_cs_n == 1'b1, "R1", "cs idle", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1", "sck idle", spi_sck, 0);
        check(req_ready == 1'b1, "R1", "ready idle", req_ready, 1);
        check(!done && !rd_valid && !wr_ready, "R1", "strobes idle",
              {done, rd_valid, wr_ready}, 0);

        // R2 R4 R7: status write selecting sequential mode
        wr_q.push_back(8'h40);
        run_req(2'd0, 15'h0000, 8'd0);
        check(last_cmd == 8'h01, "R2", "status write command", last_cmd, 8'h01);
        check(last_rises == 16, "R4", "status write edges", last_rises, 16);
        check(stat_reg == 8'h40, "R7", "status byte written", stat_reg, 8'h40);

        // R2 R8: status read
        exp_q.push_back(8'h40);
        run_req(2'd1, 15'h0000, 8'd0);
        check(last_cmd == 8'h05, "R2", "status read command", last_cmd, 8'h05);
        check(last_rises == 16, "R4", "status read edges", last_rises, 16);
        check(exp_q.size() == 0, "R8", "status byte delivered", exp_q.size(), 0);

        // R3 R7: single write
        wr_q.push_back(8'hA5);
        run_req(2'd3, 15'h0123, 8'd1);
        check(last_cmd == 8'h02, "R2", "write command", last_cmd, 8'h02);
        check(last_adr == 16'h0123, "R3", "address field", last_adr, 16'h0123);
        check(last_rises == 32, "R4", "single write edges", last_rises, 32);
        check(mem[15'h0123] == 8'hA5, "R7", "single write data", mem[15'h0123], 8'hA5);

        // R8: single read
        exp_q.push_back(8'hA5);
        run_req(2'd2, 15'h0123, 8'd1);
        check(last_cmd == 8'h03, "R2", "read command", last_cmd, 8'h03);
        check(last_rises == 32, "R4", "single read edges", last_rises, 32);

        // R4 R7 R10: four-byte write across the top of the array
        wr_q.push_back(8'h11); wr_q.push_back(8'h22); wr_q.push_back(8'h33); wr_q.push_back(8'h44);
        run_req(2'd3, 15'h7FFE, 8'd4);
        check(last_rises == 56, "R10", "length held after accept", last_rises, 56);
        check(last_adr == 16'h7FFE, "R10", "address held after accept", last_adr, 16'h7FFE);
        check(mem[15'h7FFF] == 8'h22, "R7", "second write byte", mem[15'h7FFF], 8'h22);
        check(mem[15'h0001] == 8'h44, "R7", "fourth write byte", mem[15'h0001], 8'h44);
        check(wr_q.size() == 0, "R7", "stream drained", wr_q.size(), 0);

        // R8: four-byte read of the same span
        exp_q.push_back(8'h11); exp_q.push_back(8'h22); exp_q.push_back(8'h33); exp_q.push_back(8'h44);
        run_req(2'd2, 15'h7FFE, 8'd4);
        check(last_rises == 56, "R4", "burst read edges", last_rises, 56);
        check(exp_q.size() == 0, "R8", "burst bytes delivered", exp_q.size(), 0);

        // R4: zero length counts as one byte
        exp_q.push_back(8'h00 ^ 8'h3C);
        run_req(2'd2, 15'h0200, 8'd0);
        check(last_rises == 32, "R4", "zero length edges", last_rises, 32);

        // R3: top address, field MSB must be zero
        exp_q.push_back(8'h22);
        run_req(2'd2, 15'h7FFF, 8'd1);
        check(last_adr == 16'h7FFF, "R3", "top address field", last_adr, 16'h7FFF);
        check(exp_q.size() == 0, "R8", "all reads delivered", exp_q.size(), 0);

        // R5 R6: measured timing across all frames
        check(min_half >= 25.0, "R5", "shortest sck phase ns", longint'(min_half), 25);
        check(min_setup >= 25.0, "R6", "select setup ns", longint'(min_setup), 25);
        check(min_hold >= 50.0, "R6", "select hold ns", longint'(min_hold), 50);
        check(min_gap >= 25.0, "R6", "deselect gap ns", longint'(min_gap), 25);
        repeat (10) @(negedge clk);
        check(spi_cs_n && !spi_sck && req_ready, "R1", "idle after traffic",
              {spi_cs_n, spi_sck, req_ready}, 3'b101);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule